// File: doc/BRIEF.md
# Four-Digit Seven-Segment Encoder with Selectable Zero Suppression

This block turns four packed BCD digits into four seven-segment patterns for displays whose segments light on a low level. Each digit has its own decoder stage. The stages are linked in a blanking chain, and a zero digit is blanked only while every stage ahead of it in the chain has also blanked. This removes the zeros at one end of the number and keeps the zeros that sit between nonzero digits.

The mode input sets the direction of the chain. With mode 0 the chain starts at the most significant digit, so leading zeros are removed. With mode 1 it starts at the least significant digit, so trailing zeros are removed. The last stage in the chain never blanks a zero, so a value of all zeros still shows one `0`. Codes above nine count as nonzero and always show as blank. The block is purely combinational.

Top module: `segBlankDisplay`

## Requirements
- R1: Each 7-bit segment field holds segments a..g from its MSB down to its LSB, and a 0 lights a segment. The patterns are: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R2: A digit code from 10 to 15 gives the blank pattern 1111111.
- R3: In leading mode (trailMode=0), a zero digit is blanked when every more significant digit is also zero. Digit 3 is `digitsBcd[15:12]`, the most significant digit, and its pattern is on `segOut[27:21]`. Digit i is on `digitsBcd[4i+3:4i]` and `segOut[7i+6:7i]`.
- R4: In trailing mode (trailMode=1), a zero digit is blanked when every less significant digit is also zero.
- R5: A zero digit that has a nonzero digit ahead of it in the active chain direction shows the zero pattern.
- R6: The last stage of the chain (digit 0 in leading mode, digit 3 in trailing mode) always shows a zero digit as 0000001. An all-zero input therefore shows exactly one zero.
- R7: Bit i of `rippleOut` is the blanking output of stage i. It is low exactly when that stage blanks a zero digit.
- R8: A nonzero code, including a code from 10 to 15, drives its stage's blanking output high. This stops suppression for the stages that follow it.
- R9: In leading mode, 0904 shows blank,9,0,4. In trailing mode, 9040 shows 9,0,4,blank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digitsBcd | input | 16 | Four BCD digits, digit 3 (most significant) in the top nibble |
| trailMode | input | 1 | 0 removes leading zeros, 1 removes trailing zeros |
| segOut | output | 28 | Four active-low a..g segment fields, digit 3 in the top field |
| rippleOut | output | 4 | Blanking output of each stage, low when that stage blanks a zero |

## Verification
Directed patterns cover all ten digits and the six invalid codes in each position, which separates the segment table from the chain. Zero runs at the top, at the bottom and in the middle of the number, applied in both modes, show whether the chain runs in the right direction and stops at the first nonzero digit. All-zero inputs, and zero runs cut short by an invalid code, test the forced last stage and the rule that an invalid code counts as nonzero. Random values biased toward zeros then try many mixed run lengths against a reference model in the bench.

// File: rtl/segBlankPkg.sv
package segBlankPkg;
  localparam int DIGITS = 4;
  localparam int BCD_W  = 4;
  localparam int SEG_W  = 7;
  localparam int IN_W   = DIGITS * BCD_W;
  localparam int OUT_W  = DIGITS * SEG_W;
  localparam logic [SEG_W-1:0] SEG_BLANK = {SEG_W{1'b1}};

  // strobes from the chain control to the digit stages
  typedef struct packed {
    logic [DIGITS-1:0] blankIn;
  } chainStrobes_t;

  // active-low a..g pattern for one BCD code (R1, R2)
  function automatic logic [SEG_W-1:0] segPattern(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] pat;
    case (code)
      4'd0: pat = 7'b0000001;
      4'd1: pat = 7'b1001111;
      4'd2: pat = 7'b0010010;
      4'd3: pat = 7'b0000110;
      4'd4: pat = 7'b1001100;
      4'd5: pat = 7'b0100100;
      4'd6: pat = 7'b0100000;
      4'd7: pat = 7'b0001111;
      4'd8: pat = 7'b0000000;
      4'd9: pat = 7'b0000100;
      default: pat = SEG_BLANK;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/segDigitStage.sv
module segDigitStage
  import segBlankPkg::*;
(
  input  logic [BCD_W-1:0] bcdCode,
  input  logic             blankIn,
  output logic [SEG_W-1:0] segPat,
  output logic             blankOut,
  output logic             isZero
);
  always_comb begin
    isZero = (bcdCode == '0);
    // a zero is blanked only while the chain ahead is still blank (R3, R4, R5)
    if (isZero && !blankIn) segPat = SEG_BLANK;
    else                    segPat = segPattern(bcdCode);
    // any nonzero code, valid or not, ends suppression (R7, R8)
    blankOut = blankIn | ~isZero;
  end
endmodule

// File: rtl/segChainCtrl.sv
module segChainCtrl
  import segBlankPkg::*;
(
  input  logic [DIGITS-1:0] isZero,
  input  logic              trailMode,
  output chainStrobes_t     strobes
);
  // Walk the stages in chain order. seenNonZero is the ripple signal arriving
  // at each stage. The final stage is forced to show its zero (R6).
  always_comb begin
    logic seenNonZero;
    seenNonZero = 1'b0;
    strobes = '0;
    for (int k = 0; k < DIGITS; k++) begin
      int pos;
      pos = trailMode ? k : (DIGITS - 1 - k);
      strobes.blankIn[pos] = (k == DIGITS - 1) ? 1'b1 : seenNonZero;
      seenNonZero = seenNonZero | ~isZero[pos];
    end
  end
endmodule

// File: rtl/segBlankDisplay.sv
module segBlankDisplay
  import segBlankPkg::*;
(
  input  logic [IN_W-1:0]   digitsBcd,
  input  logic              trailMode,
  output logic [OUT_W-1:0]  segOut,
  output logic [DIGITS-1:0] rippleOut
);
  logic [DIGITS-1:0] zeroFlags;
  chainStrobes_t     strobes;

  segChainCtrl uCtrl (
    .isZero   (zeroFlags),
    .trailMode(trailMode),
    .strobes  (strobes)
  );

  for (genvar i = 0; i < DIGITS; i++) begin : gStage
    segDigitStage uStage (
      .bcdCode (digitsBcd[i*BCD_W +: BCD_W]),
      .blankIn (strobes.blankIn[i]),
      .segPat  (segOut[i*SEG_W +: SEG_W]),
      .blankOut(rippleOut[i]),
      .isZero  (zeroFlags[i])
    );
  end
endmodule

// File: rtl/segBlankChecker.sv
module segBlankChecker
  import segBlankPkg::*;
(
  input logic [IN_W-1:0]   digitsBcd,
  input logic              trailMode,
  input logic [OUT_W-1:0]  segOut,
  input logic [DIGITS-1:0] rippleOut
);
  for (genvar i = 0; i < DIGITS; i++) begin : gChk
    logic [BCD_W-1:0] d;
    logic [SEG_W-1:0] s;
    assign d = digitsBcd[i*BCD_W +: BCD_W];
    assign s = segOut[i*SEG_W +: SEG_W];
    always_comb begin
      if (d > 4'd9)
        a_r2_invalid_blank: assert (s == SEG_BLANK);
      if (d != '0)
        a_r8_nonzero_ripple_high: assert (rippleOut[i]);
      if (!rippleOut[i])
        a_r7_low_ripple_is_blank_zero: assert (d == '0 && s == SEG_BLANK);
      if (d == '0 && rippleOut[i])
        a_r5_shown_zero_pattern: assert (s == 7'b0000001);
      if (d == '0 && (trailMode ? (i == DIGITS - 1) : (i == 0)))
        a_r6_last_stage_visible: assert (s == 7'b0000001);
    end
  end
endmodule

bind segBlankDisplay segBlankChecker uChk (
  .digitsBcd(digitsBcd),
  .trailMode(trailMode),
  .segOut   (segOut),
  .rippleOut(rippleOut)
);

// File: tb/tb_segBlankDisplay.sv
module tb_segBlankDisplay;
  logic        clk = 1'b0;
  logic [15:0] digitsBcd = '0;
  logic        trailMode = 1'b0;
  logic [27:0] segOut;
  logic [3:0]  rippleOut;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  segBlankDisplay dut (
    .digitsBcd(digitsBcd),
    .trailMode(trailMode),
    .segOut   (segOut),
    .rippleOut(rippleOut)
  );

  function automatic logic [6:0] refPat(input logic [3:0] c);
    logic [6:0] p;
    case (c)
      4'd0: p = 7'b0000001; 4'd1: p = 7'b1001111; 4'd2: p = 7'b0010010;
      4'd3: p = 7'b0000110; 4'd4: p = 7'b1001100; 4'd5: p = 7'b0100100;
      4'd6: p = 7'b0100000; 4'd7: p = 7'b0001111; 4'd8: p = 7'b0000000;
      4'd9: p = 7'b0000100; default: p = 7'b1111111;
    endcase
    return p;
  endfunction

  // stage i is blanked when it and every digit before it in the chain are zero, unless it is the last stage
  function automatic logic refBlanked(input logic [15:0] v, input logic m, input int i);
    logic all0;
    all0 = 1'b1;
    if (!m) begin
      for (int j = i; j < 4; j++) if (v[j*4 +: 4] != 4'd0) all0 = 1'b0;
      return all0 && (i != 0);
    end else begin
      for (int j = 0; j <= i; j++) if (v[j*4 +: 4] != 4'd0) all0 = 1'b0;
      return all0 && (i != 3);
    end
  endfunction

  function automatic logic [27:0] refSeg(input logic [15:0] v, input logic m);
    logic [27:0] r;
    for (int i = 0; i < 4; i++)
      r[i*7 +: 7] = refBlanked(v, m, i) ? 7'b1111111 : refPat(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [3:0] refRipple(input logic [15:0] v, input logic m);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ~refBlanked(v, m, i);
    return r;
  endfunction

  task automatic applyCheck(input logic [15:0] v, input logic m, input string req);
    logic [27:0] es;
    logic [3:0]  er;
    @(negedge clk);
    digitsBcd = v;
    trailMode = m;
    #2;
    es = refSeg(v, m);
    er = refRipple(v, m);
    total++;
    if (segOut !== es) begin
      bad++;
      $display("FAIL %s seg in=%h mode=%0d actual=%b expected=%b", req, v, m, segOut, es);
    end
    total++;
    if (rippleOut !== er) begin
      bad++;
      $display("FAIL %s ripple(R7) in=%h mode=%0d actual=%b expected=%b", req, v, m, rippleOut, er);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unused;
    unused = $urandom(32'd4711);
    // state before any stimulus: input all zero, leading mode (R6)
    applyCheck(16'h0000, 1'b0, "R6 initial");
    // R1: each digit in the lowest (always shown) position
    for (int d = 0; d < 10; d++) applyCheck(16'h1110 | 16'(d), 1'b0, "R1");
    // R2: invalid codes in every position
    for (int d = 10; d < 16; d++) begin
      applyCheck({4'(d), 4'(d), 4'(d), 4'(d)}, 1'b0, "R2");
      applyCheck({4'h0, 4'(d), 4'h0, 4'h0}, 1'b1, "R2/R8");
    end
    // R9 directed examples
    applyCheck(16'h0904, 1'b0, "R9 leading");
    applyCheck(16'h9040, 1'b1, "R9 trailing");
    // R3 leading zero runs, R5 internal zeros
    applyCheck(16'h0007, 1'b0, "R3");
    applyCheck(16'h0050, 1'b0, "R3/R5");
    applyCheck(16'h1000, 1'b0, "R5");
    applyCheck(16'h2003, 1'b0, "R5");
    // R4 trailing zero runs
    applyCheck(16'h7000, 1'b1, "R4");
    applyCheck(16'h0500, 1'b1, "R4/R5");
    applyCheck(16'h0001, 1'b1, "R5 trailing");
    applyCheck(16'h3002, 1'b1, "R5 trailing");
    // R6 all zero in both modes
    applyCheck(16'h0000, 1'b1, "R6 trailing");
    applyCheck(16'h0000, 1'b0, "R6 leading");
    // R8 invalid code stops suppression
    applyCheck(16'h00A0, 1'b0, "R8 leading");
    applyCheck(16'h0F00, 1'b1, "R8 trailing");
    // random mix, biased toward zero digits
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < 4; i++) begin
        int r;
        r = int'($urandom_range(0, 3));
        v[i*4 +: 4] = (r < 2) ? 4'h0 : 4'($urandom_range(0, 15));
      end
      applyCheck(v, 1'($urandom_range(0, 1)), "R3/R4 random");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule